// File: doc/BRIEF.md
# Prioritized Interrupt Latch Controller

This block collects up to 64 interrupt events in a latch, qualifies them with a per-source enable mask, and presents the most urgent qualified event to a consumer. Priority grows with the bit index, so bit 63 is the most urgent source. An in-service mask records which events are being handled. A new request is offered only if it outranks every event already in service, so nesting happens only upward.

Software sees every 64-bit register as two 32-bit words through a single register port. The register select occupies address bits [3:1] and the word half occupies address bit 0 (0 = bits 31:0, 1 = bits 63:32). The selects are:

- 0: latch
- 1: enable mask
- 2: in-service mask
- 3: set alias of the latch
- 4: clear alias of the latch

Select codes 5 to 7 do nothing. Reads are combinational on `reg_addr`. Hardware sources raise one-cycle pulses on `hw_set`.

The selected event leaves on a valid/ready channel (`irq_valid`, `irq_idx`, `irq_ready`), and a transfer happens in a cycle where both valid and ready are high. `irq_valid` has no hold rule. It can fall without a transfer, or `irq_idx` can change, when software clears the bit, when a higher event arrives, or when the in-service mask changes. The consumer must sample both signals in the cycle it asserts ready. `irq_ret` is a plain strobe that closes the newest in-service level.

Top module: `irq_latch_ctrl`

## Requirements
- R1: At reset the latch and in-service mask are zero. The enable mask resets to 0x90010061E3C3C000, or to 0x90011E61E3C3C000 when `strap_alt` is 1.
- R2: A write to select 3 ORs the data into the addressed half of the latch. A write to select 4 ANDs the data into it. The other half is unchanged.
- R3: Writes to select 0 (latch) and select 2 (in-service mask) have no effect on the stored values.
- R4: A write to select 1 replaces the addressed half of the enable mask.
- R5: A source is pending when its latch and enable bits are both 1. For bits 59:0, enable bit 60 must also be 1. Bits 63:61 ignore bit 60. Bit 60 is never pending.
- R6: `irq_idx` is the highest-numbered pending source.
- R7: `irq_valid` is 1 only if a source is pending and its index is above the highest set in-service bit (or the in-service mask is empty).
- R8: A transfer clears latch bit `irq_idx` and sets in-service bit `irq_idx` at the same edge. `irq_ready` without `irq_valid` changes nothing.
- R9: `irq_ret` clears the highest set bit of the in-service mask.
- R10: A `hw_set` pulse sets its latch bit at the next edge. It wins over a same-cycle clear alias write or transfer on that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Selects the alternate enable-mask reset value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | {select[2:0], half} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| hw_set | input | 64 | One-cycle event pulses, one per source |
| irq_valid | output | 1 | Request offered |
| irq_idx | output | 6 | Index of the offered source |
| irq_ready | input | 1 | Consumer takes the request |
| irq_ret | input | 1 | Return strobe, closes newest in-service level |

## Verification
The bench builds the block with its default parameters: 64 sources, 32-bit words, global enable at bit 60 and the ungated group from bit 61. With these values it can reach the global-enable gate, the three ungated top sources, and both word halves of every register. It also covers two nested in-service levels and both reset values of the enable mask. Same-cycle races are driven directly: a hardware pulse against a clear alias write, and a hardware pulse against a transfer on the same bit.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
  localparam int SEL_W = 3;
  typedef enum logic [SEL_W-1:0] {
    SEL_LAT = 3'd0,
    SEL_MSK = 3'd1,
    SEL_SVC = 3'd2,
    SEL_SET = 3'd3,
    SEL_CLR = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/ilc_prio_enc.sv
module ilc_prio_enc #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ilc_latch.sv
module ilc_latch #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] or_vec,
  input  logic [N-1:0] and_vec,
  input  logic [N-1:0] take_oh,
  input  logic [N-1:0] hw_set,
  output logic [N-1:0] lat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= ((lat_q | or_vec) & and_vec & ~take_oh) | hw_set;
  end

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((lat_q & $past(hw_set)) == $past(hw_set))); // R10
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import ilc_pkg::*;
#(
  parameter int N_SRC   = 64,
  parameter int WORD_W  = 32,
  parameter int GLB_POS = 60,
  parameter int NHW_LO  = 61,
  parameter logic [N_SRC-1:0] MSK_RST     = 64'h90010061E3C3C000,
  parameter logic [N_SRC-1:0] MSK_RST_ALT = 64'h90011E61E3C3C000,
  localparam int N_WORDS = N_SRC / WORD_W,
  localparam int HALF_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int ADDR_W  = SEL_W + HALF_W,
  localparam int IDX_W   = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [N_SRC-1:0]  hw_set,
  output logic              irq_valid,
  output logic [IDX_W-1:0]  irq_idx,
  input  logic              irq_ready,
  input  logic              irq_ret
);
  reg_sel_e          sel;
  logic [HALF_W-1:0] half;
  logic [N_SRC-1:0]  lat_q, msk_q, svc_q;
  logic [N_SRC-1:0]  or_vec, and_vec, gate_vec, pend;
  logic [N_SRC-1:0]  take_oh, ret_oh;
  logic              pend_any, svc_any, take;
  logic [IDX_W-1:0]  pend_top, svc_top;

  assign sel  = reg_sel_e'(reg_addr[ADDR_W-1 -: SEL_W]);
  assign half = reg_addr[HALF_W-1:0];

  // Alias write data expanded to the full latch width.
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic hit;
    assign hit = reg_wr && (int'(half) == w);
    assign or_vec[w*WORD_W +: WORD_W]  = (hit && sel == SEL_SET) ? reg_wdata : '0;
    assign and_vec[w*WORD_W +: WORD_W] = (hit && sel == SEL_CLR) ? reg_wdata : '1;
  end

  // Per-bit gate: top group ungated, bit 60 never pending, rest behind global enable.
  for (genvar i = 0; i < N_SRC; i++) begin : g_gate
    if (i >= NHW_LO)       assign gate_vec[i] = 1'b1;
    else if (i == GLB_POS) assign gate_vec[i] = 1'b0;
    else                   assign gate_vec[i] = msk_q[GLB_POS];
  end

  assign pend = lat_q & msk_q & gate_vec;

  ilc_prio_enc #(.N(N_SRC)) u_pend_enc (.vec(pend),  .any(pend_any), .idx(pend_top));
  ilc_prio_enc #(.N(N_SRC)) u_svc_enc  (.vec(svc_q), .any(svc_any),  .idx(svc_top));

  assign irq_valid = pend_any && (!svc_any || (pend_top > svc_top));
  assign irq_idx   = pend_top;
  assign take      = irq_valid && irq_ready;
  assign take_oh   = take ? (N_SRC'(1) << pend_top) : '0;
  assign ret_oh    = (irq_ret && svc_any) ? (N_SRC'(1) << svc_top) : '0;

  ilc_latch #(.N(N_SRC)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .or_vec  (or_vec),
    .and_vec (and_vec),
    .take_oh (take_oh),
    .hw_set  (hw_set),
    .lat_q   (lat_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q <= strap_alt ? MSK_RST_ALT : MSK_RST;
      svc_q <= '0;
    end else begin
      svc_q <= (svc_q & ~ret_oh) | take_oh;
      for (int w = 0; w < N_WORDS; w++) begin
        if (reg_wr && sel == SEL_MSK && int'(half) == w)
          msk_q[w*WORD_W +: WORD_W] <= reg_wdata;
      end
    end
  end

  always_comb begin
    logic [N_SRC-1:0] src;
    case (sel)
      SEL_LAT: src = lat_q;
      SEL_MSK: src = msk_q;
      SEL_SVC: src = svc_q;
      default: src = '0;
    endcase
    reg_rdata = src[int'(half)*WORD_W +: WORD_W];
  end

  AST_TAKE_SETS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> svc_q[$past(irq_idx)]); // R8
  AST_TAKE_NOT_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !svc_q[irq_idx]); // R7
  AST_IDX_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (lat_q[irq_idx] && msk_q[irq_idx])); // R5
  AST_PLAIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_LAT && hw_set == '0 && !take) |=> $stable(lat_q)); // R3
  AST_RET_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && svc_any && !take) |=> ($countones(svc_q) == $countones($past(svc_q)) - 1)); // R9
endmodule

// File: tb/tb_irq_latch_ctrl.sv
module tb_irq_latch_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_alt = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] hw_set = '0;
  logic        irq_valid;
  logic [5:0]  irq_idx;
  logic        irq_ready = 1'b0;
  logic        irq_ret = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_latch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hw_set(hw_set), .irq_valid(irq_valid), .irq_idx(irq_idx),
    .irq_ready(irq_ready), .irq_ret(irq_ret)
  );

  // {write addr, write data, read addr, expected, requirement number}
  localparam int NV = 13;
  localparam logic [79:0] TBL [NV] = '{
    {4'd2, 32'hFFFF_FFFF, 4'd2, 32'hFFFF_FFFF, 8'd4},  // R4 mask low
    {4'd3, 32'hFFFF_FFFF, 4'd3, 32'hFFFF_FFFF, 8'd4},  // R4 mask high
    {4'd6, 32'h0000_00F0, 4'd0, 32'h0000_00F0, 8'd2},  // R2 set low
    {4'd6, 32'h0000_0003, 4'd0, 32'h0000_00F3, 8'd2},  // R2 OR accumulates
    {4'd8, 32'hFFFF_FF0F, 4'd0, 32'h0000_0003, 8'd2},  // R2 AND clears
    {4'd0, 32'hDEAD_BEEF, 4'd0, 32'h0000_0003, 8'd3},  // R3 plain latch write
    {4'd7, 32'h8000_0001, 4'd1, 32'h8000_0001, 8'd2},  // R2 set high
    {4'd9, 32'h7FFF_FFFF, 4'd1, 32'h0000_0001, 8'd2},  // R2 clear high
    {4'd4, 32'hFFFF_FFFF, 4'd4, 32'h0000_0000, 8'd3},  // R3 svc low read-only
    {4'd5, 32'hFFFF_FFFF, 4'd5, 32'h0000_0000, 8'd3},  // R3 svc high read-only
    {4'd1, 32'h0000_0000, 4'd1, 32'h0000_0001, 8'd3},  // R3 plain high write
    {4'd8, 32'h0000_0000, 4'd0, 32'h0000_0000, 8'd2},  // R2 clear all low
    {4'd9, 32'h0000_0000, 4'd1, 32'h0000_0000, 8'd2}   // R2 clear all high
  };

  task automatic chk(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual=0x%08h expected=0x%08h", req, what, got, exp);
    end
  endtask

  // One clock of stimulus, applied at a falling edge and removed at the next.
  task automatic cyc(input logic [63:0] hw, input logic rdy, input logic ret,
                     input logic wr, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    hw_set = hw; irq_ready = rdy; irq_ret = ret; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    hw_set = '0; irq_ready = 1'b0; irq_ret = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc('0, 1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic chk_irq(input int req, input logic v, input logic [5:0] idx);
    #1;
    chk(req, "irq_valid", {31'd0, irq_valid}, {31'd0, v});
    if (v) chk(req, "irq_idx", {26'd0, irq_idx}, {26'd0, idx});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, v); chk(1, "latch lo reset", v, 32'h0);
    rd(4'd1, v); chk(1, "latch hi reset", v, 32'h0);
    rd(4'd2, v); chk(1, "mask lo reset", v, 32'hE3C3_C000);
    rd(4'd3, v); chk(1, "mask hi reset", v, 32'h9001_0061);
    rd(4'd5, v); chk(1, "svc hi reset", v, 32'h0);
    chk_irq(1, 1'b0, 6'd0);

    // Register-port vector table: R2 R3 R4
    for (int k = 0; k < NV; k++) begin
      wr(TBL[k][79:76], TBL[k][75:44]);
      rd(TBL[k][43:40], v);
      chk(int'(TBL[k][7:0]), "table", v, TBL[k][39:8]);
    end

    // R5 global enable gate and ungated top group
    wr(4'd3, 32'hEFFF_FFFF);
    wr(4'd6, 32'h0000_0020);
    chk_irq(5, 1'b0, 6'd0);
    wr(4'd7, 32'h2000_0000);
    chk_irq(5, 1'b1, 6'd61);
    wr(4'd9, 32'hDFFF_FFFF);
    chk_irq(5, 1'b0, 6'd0);
    wr(4'd3, 32'hFFFF_FFFF);
    chk_irq(5, 1'b1, 6'd5);

    // R6 highest index chosen
    wr(4'd7, 32'h0000_0100);
    chk_irq(6, 1'b1, 6'd40);

    // R8 transfer moves bit 40 to in-service
    cyc('0, 1'b1, 1'b0, 1'b0, 4'd0, 32'h0);
    rd(4'd1, v); chk(8, "latch hi after take", v, 32'h0);
    rd(4'd5, v); chk(8, "svc hi after take", v, 32'h0000_0100);
    chk_irq(7, 1'b0, 6'd0);

    // R7 higher source nests
    wr(4'd7, 32'h0000_2000);
    chk_irq(7, 1'b1, 6'd45);
    cyc('0, 1'b1, 1'b0, 1'b0, 4'd0, 32'h0);
    rd(4'd5, v); chk(8, "svc hi nested", v, 32'h0000_2100);

    // R9 returns unwind newest first
    cyc('0, 1'b0, 1'b1, 1'b0, 4'd0, 32'h0);
    rd(4'd5, v); chk(9, "svc hi after ret", v, 32'h0000_0100);
    cyc('0, 1'b0, 1'b1, 1'b0, 4'd0, 32'h0);
    rd(4'd5, v); chk(9, "svc hi after 2nd ret", v, 32'h0);
    chk_irq(7, 1'b1, 6'd5);

    // R10 hardware pulse beats clear alias
    wr(4'd8, 32'h0);
    cyc(64'h80, 1'b0, 1'b0, 1'b1, 4'd8, 32'h0);
    rd(4'd0, v); chk(10, "hw vs clear", v, 32'h0000_0080);
    chk_irq(10, 1'b1, 6'd7);
    // R10 hardware pulse beats transfer on same bit
    cyc(64'h80, 1'b1, 1'b0, 1'b0, 4'd0, 32'h0);
    rd(4'd0, v); chk(10, "hw vs take latch", v, 32'h0000_0080);
    rd(4'd4, v); chk(10, "hw vs take svc", v, 32'h0000_0080);
    cyc('0, 1'b0, 1'b1, 1'b0, 4'd0, 32'h0);
    cyc(64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 4'd0, 32'h0);
    rd(4'd1, v); chk(10, "hw pulse sets bit 63", v, 32'h8000_0000);
    chk_irq(6, 1'b1, 6'd63);

    // R8 ready without valid does nothing
    wr(4'd8, 32'h0);
    wr(4'd9, 32'h0);
    chk_irq(8, 1'b0, 6'd0);
    cyc('0, 1'b1, 1'b0, 1'b0, 4'd0, 32'h0);
    rd(4'd4, v); chk(8, "svc lo idle ready", v, 32'h0);
    rd(4'd5, v); chk(8, "svc hi idle ready", v, 32'h0);

    // R1 alternate reset value
    @(negedge clk);
    strap_alt = 1'b1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'd3, v); chk(1, "mask hi alt reset", v, 32'h9001_1E61);
    rd(4'd2, v); chk(1, "mask lo alt reset", v, 32'hE3C3_C000);
    rd(4'd0, v); chk(1, "latch lo alt reset", v, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule